// File: doc/BRIEF.md
# Random Number Output Buffer and Status Front End

This block sits between a free-running entropy source and a processor's register bus. While generation is enabled it takes one entropy bit per clock into a block of output words. Once a programmed number of cycles has been collected, it raises a ready flag. Software then reads the words and writes a one to the ready bit of the status register, which drops ready and starts the next refill. The refill length comes from a minimum and a maximum cycle-count field in the configuration register.

The block also holds the status bits for the external health tests. Each bit is set by a pulse from the test logic and cleared by writing a one to it. A per-cause enable in the control register masks each bit onto a single interrupt line. The block compares every completed output block with the one before it and flags a repeat in a status bit of its own. It also holds several plain storage registers for the oscillator bank and alarm logic, plus a read-only options word and a read-only revision word. The bus is a single-cycle port: writes take effect at the clock edge, and read data is combinational from the address.

Top module: `rng_front`

## Requirements
- R1: After a synchronous active-low reset, every writable register, the status register, the output words and irq read as zero.
- R2: Control keeps only bit 10 (generation enable) and bits 7:1 (interrupt enables). Config keeps bits 31:16 (maximum refill cycles) and bits 7:0 (minimum refill cycles). Alarm count at 0x1C keeps bits 7:0. The 32-bit registers at 0x20, 0x24, 0x28 and 0x2C keep every bit. Unkept bits read zero.
- R3: While ready is low and control bit 10 is set, each clock shifts the entropy input into bit 0 of the 128-bit block, and older bits move up. The fill count pauses while bit 10 is clear. Ready rises at the clock that completes T enabled cycles. T is the maximum field if that is at least the minimum field, otherwise the minimum field, and 1 if the result is 0.
- R4: A write to status at 0x10 with data bit 0 set clears ready and restarts the fill count at zero. A status write with bit 0 clear leaves ready unchanged.
- R5: Output word k (k = 0..3) reads at byte address 4k and returns block bits 32k+31:32k while ready is high, and zero while ready is low.
- R6: Status bit i+3 is set by a pulse on hlth_fail[i] (i = 0..4), and bit 1 is set by shdn_ovf. Bits 7:1 clear only by writing a one to them at 0x10. A set and a clear in the same cycle leave the bit set.
- R7: Status bit 2 is set when a newly completed block equals the previous completed block. The first block after reset never sets it.
- R8: irq is high exactly when some status bit in 7:1 is set and the matching control bit is set.
- R9: Revision at 0x7C reads {4'b0, major, minor, patch, 16'b0}, and options at 0x78 reads its parameter value. Writes to either register are ignored. Unmapped or unaligned addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| ent_bit | input | 1 | Entropy bit, one per cycle |
| hlth_fail | input | 5 | Health-test failure pulses for status bits 7:3 |
| shdn_ovf | input | 1 | Shutdown overflow pulse for status bit 1 |
| irq | output | 1 | Interrupt request |

## Verification
Every register, the ready flag and the status bits change at the clock edge that samples the write or pulse. Read data and irq follow combinationally in the same cycle, so each result is due one edge after its stimulus. The bench's reference model advances at the same edge and is compared 1 ns after every rising edge, while inputs change only at falling edges. The ready latency is measured directly: counting from the acknowledging write, the first status read that shows ready must come exactly T cycles later.

// File: rtl/rng_front_pkg.sv
// Shared register offsets and status bit positions for the random number front end.
package rng_front_pkg;
    localparam int ADDR_W = 7;
    localparam logic [ADDR_W-1:0] OFS_STS      = 7'h10;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 7'h14;
    localparam logic [ADDR_W-1:0] OFS_CFG      = 7'h18;
    localparam logic [ADDR_W-1:0] OFS_ALM      = 7'h1C;
    localparam logic [ADDR_W-1:0] OFS_MISC0    = 7'h20;
    localparam logic [ADDR_W-1:0] OFS_OPT      = 7'h78;
    localparam logic [ADDR_W-1:0] OFS_REV      = 7'h7C;
    localparam int MISC_N      = 4;
    localparam int CTRL_EN_BIT = 10;
    localparam int ST_READY    = 0;
    localparam int ST_SHDN     = 1;
    localparam int ST_STUCK    = 2;
    localparam int ST_HLTH_LO  = 3;
    localparam int ST_TOP      = 7;
endpackage

// File: rtl/rng_cfg_regs.sv
// Writable control, configuration, alarm and plain storage registers.
// Assumes a single-cycle write strobe with a byte address that is a multiple of four.
module rng_cfg_regs
    import rng_front_pkg::*;
#(
    parameter int DW    = 32,
    parameter int MAX_W = 16,
    parameter int MIN_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DW-1:0]               wdata,
    output logic                        gen_en,
    output logic [ST_TOP:1]             irq_en,
    output logic [MAX_W-1:0]            max_cyc,
    output logic [MIN_W-1:0]            min_cyc,
    output logic [MIN_W-1:0]            alm_thr,
    output logic [MISC_N-1:0][DW-1:0]   misc
);
    // Control fields: generation enable and per-cause interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en <= 1'b0;
            irq_en <= '0;
        end else if (wr && addr == OFS_CTRL) begin
            gen_en <= wdata[CTRL_EN_BIT];
            irq_en <= wdata[ST_TOP:1];
        end
    end

    // Refill pacing fields and alarm threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_cyc <= '0;
            min_cyc <= '0;
            alm_thr <= '0;
        end else if (wr) begin
            if (addr == OFS_CFG) begin
                max_cyc <= wdata[DW-1 -: MAX_W];
                min_cyc <= wdata[MIN_W-1:0];
            end
            if (addr == OFS_ALM) alm_thr <= wdata[MIN_W-1:0];
        end
    end

    // Full-width storage registers at consecutive word offsets.
    for (genvar g = 0; g < MISC_N; g++) begin : g_misc
        localparam logic [ADDR_W-1:0] OFS = OFS_MISC0 + ADDR_W'(4 * g);
        always_ff @(posedge clk) begin
            if (!rst_n)                   misc[g] <= '0;
            else if (wr && addr == OFS)   misc[g] <= wdata;
        end
    end
endmodule

// File: rtl/rng_fill.sv
// Collects entropy bits into the output block, paces the refill and raises ready.
// Also flags a completed block that repeats the previous one.
// Assumes ack takes priority over a refill step in the same cycle.
module rng_fill #(
    parameter int BLK_W = 128,
    parameter int MAX_W = 16,
    parameter int MIN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_en,
    input  logic              ent_bit,
    input  logic              ack,
    input  logic [MAX_W-1:0]  max_cyc,
    input  logic [MIN_W-1:0]  min_cyc,
    output logic              ready,
    output logic [BLK_W-1:0]  blk,
    output logic              stuck_set
);
    localparam int CW = MAX_W + 1;

    logic [CW-1:0]    cnt_q, cnt_inc, tgt;
    logic [BLK_W-1:0] nxt_blk, prev_q;
    logic             have_prev, step, done;

    // Pick the refill length from the pacing fields.
    always_comb begin
        tgt = (max_cyc >= MAX_W'(min_cyc)) ? CW'(max_cyc) : CW'(min_cyc);
        if (tgt == '0) tgt = CW'(1);
    end

    assign cnt_inc   = cnt_q + CW'(1);
    assign step      = gen_en && !ready && !ack;
    assign done      = step && (cnt_inc >= tgt);
    assign nxt_blk   = {blk[BLK_W-2:0], ent_bit};
    assign stuck_set = done && have_prev && (nxt_blk == prev_q);

    // Shift, count and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
            cnt_q <= '0;
            blk   <= '0;
        end else if (ack) begin
            ready <= 1'b0;
            cnt_q <= '0;
        end else if (step) begin
            blk   <= nxt_blk;
            cnt_q <= done ? '0 : cnt_inc;
            if (done) ready <= 1'b1;
        end
    end

    // Remember the last completed block for the repeat check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            have_prev <= 1'b0;
        end else if (done) begin
            prev_q    <= nxt_blk;
            have_prev <= 1'b1;
        end
    end
endmodule

// File: rtl/rng_status.sv
// Sticky status bits 7:1 with write-one-to-clear and the masked interrupt line.
// Assumes a set pulse wins over a clear in the same cycle.
module rng_status
    import rng_front_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ST_TOP:1]  set,
    input  logic [ST_TOP:1]  clr,
    input  logic [ST_TOP:1]  irq_en,
    output logic [ST_TOP:1]  sts,
    output logic             irq
);
    for (genvar b = 1; b <= ST_TOP; b++) begin : g_bit
        // One sticky cause bit.
        always_ff @(posedge clk) begin
            if (!rst_n)      sts[b] <= 1'b0;
            else if (set[b]) sts[b] <= 1'b1;
            else if (clr[b]) sts[b] <= 1'b0;
        end
    end

    assign irq = |(sts & irq_en);
endmodule

// File: rtl/rng_front.sv
// Register front end for a hardware random number source: output block,
// status, control and identification registers on a single-cycle bus.
// Assumes read data is sampled in the same cycle as the address.
module rng_front
    import rng_front_pkg::*;
#(
    parameter int          WORDS     = 4,
    parameter int          WORD_W    = 32,
    parameter int          MAX_W     = 16,
    parameter int          MIN_W     = 8,
    parameter logic [3:0]  REV_MAJOR = 4'h1,
    parameter logic [3:0]  REV_MINOR = 4'h0,
    parameter logic [3:0]  REV_PATCH = 4'h0,
    parameter logic [31:0] OPT_VAL   = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [6:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ent_bit,
    input  logic [4:0]        hlth_fail,
    input  logic              shdn_ovf,
    output logic              irq
);
    localparam int BLK_W = WORDS * WORD_W;
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic                      gen_en, ready_w, stuck_set, wr_sts, ack;
    logic [ST_TOP:1]           irq_en, sts_w, set_v, clr_v;
    logic [MAX_W-1:0]          max_cyc;
    logic [MIN_W-1:0]          min_cyc, alm_thr;
    logic [MISC_N-1:0][31:0]   misc;
    logic [WORDS-1:0][WORD_W-1:0] words;
    logic [4:0]                widx;

    assign wr_sts = bus_wr && bus_addr == OFS_STS;
    assign ack    = wr_sts && bus_wdata[ST_READY];
    assign clr_v  = wr_sts ? bus_wdata[ST_TOP:1] : '0;
    assign set_v  = {hlth_fail, stuck_set, shdn_ovf};
    assign widx   = bus_addr[6:2];

    rng_cfg_regs #(.DW(32), .MAX_W(MAX_W), .MIN_W(MIN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .gen_en(gen_en), .irq_en(irq_en), .max_cyc(max_cyc), .min_cyc(min_cyc),
        .alm_thr(alm_thr), .misc(misc)
    );

    rng_fill #(.BLK_W(BLK_W), .MAX_W(MAX_W), .MIN_W(MIN_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .ent_bit(ent_bit), .ack(ack),
        .max_cyc(max_cyc), .min_cyc(min_cyc), .ready(ready_w), .blk(words),
        .stuck_set(stuck_set)
    );

    rng_status u_sts (
        .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v), .irq_en(irq_en),
        .sts(sts_w), .irq(irq)
    );

    // Read multiplexer; output words are hidden until ready.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[1:0] == 2'b00 && 32'(widx) < WORDS) begin
            if (ready_w) bus_rdata = 32'(words[widx[IDX_W-1:0]]);
        end else begin
            case (bus_addr)
                OFS_STS:         bus_rdata = {24'b0, sts_w, ready_w};
                OFS_CTRL:        bus_rdata = 32'({gen_en, 2'b00, irq_en, 1'b0});
                OFS_CFG:         bus_rdata = {max_cyc, 8'b0, min_cyc};
                OFS_ALM:         bus_rdata = 32'(alm_thr);
                OFS_MISC0:       bus_rdata = misc[0];
                OFS_MISC0 + 4:   bus_rdata = misc[1];
                OFS_MISC0 + 8:   bus_rdata = misc[2];
                OFS_MISC0 + 12:  bus_rdata = misc[3];
                OFS_OPT:         bus_rdata = OPT_VAL;
                OFS_REV:         bus_rdata = {4'b0, REV_MAJOR, REV_MINOR, REV_PATCH, 16'b0};
                default:         bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rng_front_chk.sv
// Temporal checks on the front end, attached to every instance by bind.
module rng_front_chk
    import rng_front_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [6:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [4:0]  hlth_fail,
    input logic        irq,
    input logic        ready,
    input logic [7:1]  sts,
    input logic        gen_en
);
    assert_ready_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(gen_en));

    assert_ack_clears_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_STS && bus_wdata[0]) |=> !ready);

    assert_ready_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !(bus_wr && bus_addr == OFS_STS && bus_wdata[0])) |=> ready);

    assert_words_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && bus_addr[6:4] == 3'b000) |-> bus_rdata == 32'h0);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_STS) |=> ((sts & $past(sts)) == $past(sts)));

    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_STS) |=>
            ((sts[7:3] & $past(bus_wdata[7:3] & ~hlth_fail)) == 5'b0));

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (|sts));

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL && bus_wdata[7:1] == 7'b0) |=> !irq);
endmodule

bind rng_front rng_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hlth_fail(hlth_fail),
    .irq(irq), .ready(ready_w), .sts(sts_w), .gen_en(gen_en)
);

// File: tb/test_rng_front.sv
`timescale 1ns/1ps
module test_rng_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = 7'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        ent_bit = 1'b0;
    logic [4:0]  hlth_fail = 5'b0;
    logic        shdn_ovf = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    localparam logic [31:0] EXP_REV = 32'h0321_0000;
    localparam logic [31:0] EXP_OPT = 32'h0000_0044;

    always #2 clk = ~clk;

    rng_front #(.REV_MAJOR(4'h3), .REV_MINOR(4'h2), .REV_PATCH(4'h1), .OPT_VAL(EXP_OPT))
        i_rng_front (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ent_bit(ent_bit),
        .hlth_fail(hlth_fail), .shdn_ovf(shdn_ovf), .irq(irq)
    );

    // Entropy stimulus: pseudo-random or constant zero.
    logic [15:0] lfsr = 16'hACE1;
    bit          ent_zero = 1'b0;
    always @(negedge clk) begin
        ent_bit = ent_zero ? 1'b0 : lfsr[0];
        lfsr    = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end

    // Behavioural reference model.
    logic [127:0] m_buf, m_prev;
    logic [7:1]   m_sts;
    logic         m_ready, m_have;
    int           m_cnt;
    logic [31:0]  m_ctrl, m_cfg, m_alm;
    logic [31:0]  m_misc [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_buf = '0; m_prev = '0; m_sts = '0; m_ready = 0; m_have = 0; m_cnt = 0;
            m_ctrl = 0; m_cfg = 0; m_alm = 0;
            foreach (m_misc[i]) m_misc[i] = 0;
        end else begin
            bit wrs, ackv, fin, stk;
            int mx, mn, tg;
            logic [127:0] nb;
            wrs  = bus_wr && bus_addr == 7'h10;
            ackv = wrs && bus_wdata[0];
            fin  = 0;
            nb   = m_buf;
            mx = int'(m_cfg[31:16]); mn = int'(m_cfg[7:0]);
            tg = (mx >= mn) ? mx : mn;
            if (tg == 0) tg = 1;
            if (ackv) begin
                m_ready = 0; m_cnt = 0;
            end else if (!m_ready && m_ctrl[10]) begin
                nb = {m_buf[126:0], ent_bit};
                m_cnt++;
                if (m_cnt >= tg) begin m_ready = 1; m_cnt = 0; fin = 1; end
                m_buf = nb;
            end
            stk = fin && m_have && (nb == m_prev);
            if (fin) begin m_prev = nb; m_have = 1; end
            for (int b = 1; b <= 7; b++) begin
                bit s;
                s = (b == 1) ? shdn_ovf : (b == 2) ? stk : hlth_fail[b-3];
                if (s) m_sts[b] = 1;
                else if (wrs && bus_wdata[b]) m_sts[b] = 0;
            end
            if (bus_wr) begin
                case (bus_addr)
                    7'h14: m_ctrl = bus_wdata & 32'h0000_04FE;
                    7'h18: m_cfg  = bus_wdata & 32'hFFFF_00FF;
                    7'h1C: m_alm  = bus_wdata & 32'h0000_00FF;
                    7'h20: m_misc[0] = bus_wdata;
                    7'h24: m_misc[1] = bus_wdata;
                    7'h28: m_misc[2] = bus_wdata;
                    7'h2C: m_misc[3] = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [6:0] a);
        if (a[1:0] != 2'b00) return 0;
        if (a < 7'h10) return m_ready ? 32'(m_buf >> (32 * int'(a[6:2]))) : 32'h0;
        case (a)
            7'h10: return {24'b0, m_sts, m_ready};
            7'h14: return m_ctrl;
            7'h18: return m_cfg;
            7'h1C: return m_alm;
            7'h20: return m_misc[0];
            7'h24: return m_misc[1];
            7'h28: return m_misc[2];
            7'h2C: return m_misc[3];
            7'h78: return EXP_OPT;
            7'h7C: return EXP_REV;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input logic [6:0] a);
        if (a < 7'h10)  return "R5";
        if (a == 7'h10) return "R6";
        if (a <= 7'h2C) return "R2";
        return "R9";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the model, 1 ns after the rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && !done_flag) begin
            check(tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
            check("R8", 32'(irq), 32'(|(m_sts & m_ctrl[7:1])));
        end
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Count cycles from the edge after an acknowledge until ready is seen.
    task automatic wait_ready(output int n);
        n = 0;
        bus_addr = 7'h10;
        #1;
        while (!bus_rdata[0] && n < 20000) begin
            @(negedge clk); #1; n++;
        end
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values
        for (int a = 0; a < 8'h30; a += 4) begin
            rd(7'(a), d); check("R1", d, 32'h0);
        end
        check("R1", 32'(irq), 0);
        // R9: identification and unmapped
        rd(7'h7C, d); check("R9", d, EXP_REV);
        rd(7'h78, d); check("R9", d, EXP_OPT);
        wr(7'h7C, 32'hFFFF_FFFF); rd(7'h7C, d); check("R9", d, EXP_REV);
        rd(7'h40, d); check("R9", d, 0);
        // R2: register storage and masks
        wr(7'h14, 32'hFFFF_FFFF); rd(7'h14, d); check("R2", d, 32'h0000_04FE);
        wr(7'h14, 32'h0); 
        wr(7'h18, 32'h1234_5678); rd(7'h18, d); check("R2", d, 32'h1234_0078);
        wr(7'h1C, 32'hABCD_EF5A); rd(7'h1C, d); check("R2", d, 32'h0000_005A);
        wr(7'h24, 32'hDEAD_BEEF); rd(7'h24, d); check("R2", d, 32'hDEAD_BEEF);
        wr(7'h2C, 32'h0F0F_0F0F); rd(7'h2C, d); check("R2", d, 32'h0F0F_0F0F);
        rd(7'h13, d); check("R9", d, 0);
        // R3: full-block refill length
        wr(7'h18, 32'h0080_000A);
        wr(7'h14, 32'h0000_04FE);
        wr(7'h10, 32'h1);
        wait_ready(n); check("R3", 32'(n), 128);
        for (int k = 0; k < 4; k++) begin rd(7'(4*k), d); end
        // R4: a zero in bit 0 leaves ready
        wr(7'h10, 32'h0000_00FE); rd(7'h10, d); check("R4", 32'(d[0]), 1);
        wr(7'h10, 32'h1); rd(7'h10, d); check("R4", 32'(d[0]), 0);
        // R5: words hidden while not ready
        rd(7'h04, d); check("R5", d, 0);
        // R3: minimum above maximum
        wr(7'h18, 32'h0005_0014); wr(7'h10, 32'h1);
        wait_ready(n); check("R3", 32'(n), 20);
        // R3: zero length behaves as one cycle
        wr(7'h18, 32'h0); wr(7'h10, 32'h1);
        wait_ready(n); check("R3", 32'(n), 1);
        // R3: pause while disabled
        wr(7'h18, 32'h0040_0000); wr(7'h10, 32'h1);
        repeat (10) @(negedge clk);
        wr(7'h14, 32'h0000_00FE);
        repeat (80) @(negedge clk);
        rd(7'h10, d); check("R3", 32'(d[0]), 0);
        wr(7'h14, 32'h0000_04FE);
        wait_ready(n);
        rd(7'h0C, d);
        // R7: repeated blocks raise the stuck bit
        wr(7'h18, 32'h0080_0000);
        @(negedge clk); ent_zero = 1;
        wr(7'h10, 32'h1); wait_ready(n);
        wr(7'h10, 32'h4); rd(7'h10, d); check("R7", 32'(d[2]), 0);
        wr(7'h10, 32'h1); wait_ready(n);
        rd(7'h10, d); check("R7", 32'(d[2]), 1);
        check("R8", 32'(irq), 1);
        rd(7'h08, d); check("R5", d, 0);
        wr(7'h10, 32'hFF);
        ent_zero = 0;
        // R6: health pulses, clear and set-over-clear
        @(negedge clk); hlth_fail = 5'b10101; shdn_ovf = 1;
        @(negedge clk); hlth_fail = 5'b0; shdn_ovf = 0;
        rd(7'h10, d); check("R6", d & 32'hAA, 32'hAA);
        check("R8", 32'(irq), 1);
        wr(7'h10, 32'hAA); rd(7'h10, d); check("R6", d & 32'hAA, 32'h0);
        @(negedge clk); bus_wr = 1; bus_addr = 7'h10; bus_wdata = 32'h08; hlth_fail = 5'b00001;
        @(negedge clk); bus_wr = 0; hlth_fail = 5'b0;
        rd(7'h10, d); check("R6", 32'(d[3]), 1);
        // R8: masking by enable bits
        wr(7'h14, 32'h0000_0400); check("R8", 32'(irq), 0);
        wr(7'h14, 32'h0000_0408); check("R8", 32'(irq), 1);
        wr(7'h10, 32'h08); check("R8", 32'(irq), 0);
        // R1: reset mid-run returns to zero state
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd(7'h14, d); check("R1", d, 0);
        rd(7'h10, d); check("R1", d, 0);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule